// File: doc/BRIEF.md
# Sixteen-bit instruction decoder

This block turns one 16-bit instruction word of a small load/store machine with eight general registers into everything the datapath needs for that instruction. It is purely combinational. It splits out the three register address fields and builds a 16-bit immediate. The immediate comes from bit fields whose positions depend on the instruction format. It also drives the control lines: register write, write-address select, ALU operand select, ALU operation, memory write, result select and branch.

The low three bits of the word carry the major opcode. Register-to-register instructions put their operation code in the top nibble of the word. Ten instructions are decoded. Every other bit pattern raises an illegal flag and leaves every control line low, so the word cannot change any architectural state. The register file, memories, program counter and sequencing sit outside this block.

Top module: `isa16_decoder`

## Requirements
- R1: The opcode in bits 2:0 is decoded as 001 register-register, 010 add-immediate, 011 branch-if-equal, 100 load, 101 store and 110 load-upper. Opcodes 000 and 111 assert `illegal_o`.
- R2: Under opcode 001, bits 15:12 select `alu_op_o`: 0001 gives OR (001), 0010 gives AND (000), 0011 gives add (010), 0111 gives subtract (110) and 1111 gives signed set-on-less-than (111). Any other nibble asserts `illegal_o`.
- R3: `rt_o` always equals bits 11:9, `rs_o` bits 8:6 and `rd_o` bits 5:3, whatever the opcode.
- R4: For add-immediate and load, `imm_o` is the 7-bit two's complement value {bits 15:12, bits 11:9}, sign-extended to 16 bits.
- R5: For branch-if-equal and store, `imm_o` is the 7-bit two's complement value {bits 15:12, bits 5:3}, sign-extended to 16 bits.
- R6: For load-upper, `imm_o` is the unsigned bits 15:6 shifted left by six (low six bits zero). The decoder asserts `reg_we_o` with `result_sel_o` = 10 (immediate).
- R7: A load asserts `reg_we_o`, `alu_src_o` = 1, `alu_op_o` = add and `result_sel_o` = 01 (memory). A store asserts `mem_we_o`, `alu_src_o` = 1 and add, with `reg_we_o` low. Add-immediate asserts `reg_we_o`, `alu_src_o` = 1, add and `result_sel_o` = 00 (ALU).
- R8: Branch-if-equal asserts `branch_o` only. `reg_we_o` and `mem_we_o` stay low. `branch_o` is low for every other word.
- R9: When `illegal_o` is high, every other control output is zero, including both write enables, and `imm_o` is zero.
- R10: A legal register-register word asserts `reg_we_o` with `alu_src_o` = 0 and `result_sel_o` = 00. Its `imm_o` is zero.
- R11: `dst_sel_o` is 1 (write address taken from bits 5:3) exactly when `reg_we_o` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| rs_o | output | 3 | First source register field |
| rt_o | output | 3 | Second source register field |
| rd_o | output | 3 | Destination register field |
| imm_o | output | 16 | Assembled, extended or shifted immediate |
| reg_we_o | output | 1 | Register file write enable |
| dst_sel_o | output | 1 | Write address select, 1 = bits 5:3 |
| alu_src_o | output | 1 | ALU second operand, 1 = immediate |
| alu_op_o | output | 3 | ALU operation code |
| mem_we_o | output | 1 | Data memory write enable |
| result_sel_o | output | 2 | Write-back source: 00 ALU, 01 memory, 10 immediate |
| branch_o | output | 1 | Conditional branch instruction |
| illegal_o | output | 1 | Undefined opcode or operation nibble |

## Verification
The bench aims at the sign bit of both 7-bit immediate layouts. A decoder that took the low three bits from the wrong field, or that zero-extended, would give a wrong offset for negative values such as -64 and -1. Load-upper with all ones in bits 15:6 would expose a shift by the wrong amount or a sign extension. Every unlisted operation nibble is driven under opcode 001, together with opcodes 000 and 111. A decoder that lets any of them through would raise a write enable or leave `illegal_o` low. Random words cover the rest of the space and check that the register fields never move with the format.

// File: rtl/isa16_pkg.sv
package isa16_pkg;

    parameter int unsigned WORD_W = 16;
    parameter int unsigned REG_AW = 3;
    parameter int unsigned OPC_W  = 3;
    parameter int unsigned FN_W   = 4;
    parameter int unsigned SIMM_W = 7;
    parameter int unsigned UIMM_W = 10;
    parameter int unsigned UP_SH  = 6;

    localparam int unsigned FN_LSB  = WORD_W - FN_W;
    localparam int unsigned RT_LSB  = 9;
    localparam int unsigned RS_LSB  = 6;
    localparam int unsigned RD_LSB  = 3;
    localparam int unsigned LOW3_W  = SIMM_W - FN_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_RSV0 = 3'b000,
        OPC_RRR  = 3'b001,
        OPC_ADDI = 3'b010,
        OPC_BEQ  = 3'b011,
        OPC_LOAD = 3'b100,
        OPC_STOR = 3'b101,
        OPC_LUPP = 3'b110,
        OPC_RSV7 = 3'b111
    } opc_e;

    localparam logic [FN_W-1:0] FN_OR  = 4'b0001;
    localparam logic [FN_W-1:0] FN_AND = 4'b0010;
    localparam logic [FN_W-1:0] FN_ADD = 4'b0011;
    localparam logic [FN_W-1:0] FN_SUB = 4'b0111;
    localparam logic [FN_W-1:0] FN_SLT = 4'b1111;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_e;

    typedef enum logic [1:0] {
        RES_ALU = 2'b00,
        RES_MEM = 2'b01,
        RES_IMM = 2'b10
    } res_e;

    typedef enum logic [1:0] {
        IMK_NONE  = 2'd0,
        IMK_MID   = 2'd1,
        IMK_SPLIT = 2'd2,
        IMK_UPPER = 2'd3
    } imk_e;

    typedef struct packed {
        logic reg_we;
        logic dst_sel;
        logic alu_src;
        alu_e alu_op;
        logic mem_we;
        res_e res_sel;
        logic branch;
        logic illegal;
    } ctrl_t;

    localparam ctrl_t CTRL_QUIET = '{
        reg_we: 1'b0, dst_sel: 1'b0, alu_src: 1'b0, alu_op: ALU_AND,
        mem_we: 1'b0, res_sel: RES_ALU, branch: 1'b0, illegal: 1'b0
    };

    function automatic logic [WORD_W-1:0] sext_simm(input logic [SIMM_W-1:0] v);
        return {{(WORD_W-SIMM_W){v[SIMM_W-1]}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] upper_imm(input logic [UIMM_W-1:0] v);
        return {v, {UP_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/isa16_fields.sv
module isa16_fields
    import isa16_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output opc_e              opc_o,
    output logic [FN_W-1:0]   fn_o,
    output logic [REG_AW-1:0] rs_o,
    output logic [REG_AW-1:0] rt_o,
    output logic [REG_AW-1:0] rd_o
);
    assign opc_o = opc_e'(word_i[OPC_W-1:0]);
    assign fn_o  = word_i[WORD_W-1:FN_LSB];
    assign rt_o  = word_i[RT_LSB +: REG_AW];
    assign rs_o  = word_i[RS_LSB +: REG_AW];
    assign rd_o  = word_i[RD_LSB +: REG_AW];
endmodule

// File: rtl/isa16_ctrl.sv
module isa16_ctrl
    import isa16_pkg::*;
(
    input  opc_e            opc_i,
    input  logic [FN_W-1:0] fn_i,
    output ctrl_t           ctrl_o,
    output imk_e            imk_o
);
    logic fn_ok;
    alu_e fn_alu;

    always_comb begin
        fn_ok  = 1'b1;
        fn_alu = ALU_AND;
        case (fn_i)
            FN_OR:   fn_alu = ALU_OR;
            FN_AND:  fn_alu = ALU_AND;
            FN_ADD:  fn_alu = ALU_ADD;
            FN_SUB:  fn_alu = ALU_SUB;
            FN_SLT:  fn_alu = ALU_SLT;
            default: fn_ok  = 1'b0;
        endcase
    end

    always_comb begin
        ctrl_o = CTRL_QUIET;
        imk_o  = IMK_NONE;
        case (opc_i)
            OPC_RRR: begin
                if (fn_ok) begin
                    ctrl_o.reg_we  = 1'b1;
                    ctrl_o.dst_sel = 1'b1;
                    ctrl_o.alu_op  = fn_alu;
                end else begin
                    ctrl_o.illegal = 1'b1;
                end
            end
            OPC_ADDI: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.dst_sel = 1'b1;
                ctrl_o.alu_src = 1'b1;
                ctrl_o.alu_op  = ALU_ADD;
                imk_o          = IMK_MID;
            end
            OPC_LOAD: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.dst_sel = 1'b1;
                ctrl_o.alu_src = 1'b1;
                ctrl_o.alu_op  = ALU_ADD;
                ctrl_o.res_sel = RES_MEM;
                imk_o          = IMK_MID;
            end
            OPC_STOR: begin
                ctrl_o.mem_we  = 1'b1;
                ctrl_o.alu_src = 1'b1;
                ctrl_o.alu_op  = ALU_ADD;
                imk_o          = IMK_SPLIT;
            end
            OPC_BEQ: begin
                ctrl_o.branch  = 1'b1;
                imk_o          = IMK_SPLIT;
            end
            OPC_LUPP: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.dst_sel = 1'b1;
                ctrl_o.res_sel = RES_IMM;
                imk_o          = IMK_UPPER;
            end
            default: begin
                ctrl_o.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/isa16_imm.sv
module isa16_imm
    import isa16_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  imk_e              imk_i,
    output logic [WORD_W-1:0] imm_o
);
    logic [SIMM_W-1:0] raw_mid;
    logic [SIMM_W-1:0] raw_split;
    logic [UIMM_W-1:0] raw_up;

    assign raw_mid   = {word_i[WORD_W-1:FN_LSB], word_i[RT_LSB +: LOW3_W]};
    assign raw_split = {word_i[WORD_W-1:FN_LSB], word_i[RD_LSB +: LOW3_W]};
    assign raw_up    = word_i[WORD_W-1 -: UIMM_W];

    always_comb begin
        case (imk_i)
            IMK_MID:   imm_o = sext_simm(raw_mid);
            IMK_SPLIT: imm_o = sext_simm(raw_split);
            IMK_UPPER: imm_o = upper_imm(raw_up);
            default:   imm_o = '0;
        endcase
    end
endmodule

// File: rtl/isa16_decoder.sv
module isa16_decoder
    import isa16_pkg::*;
(
    input  logic [15:0] instr_i,
    output logic [2:0]  rs_o,
    output logic [2:0]  rt_o,
    output logic [2:0]  rd_o,
    output logic [15:0] imm_o,
    output logic        reg_we_o,
    output logic        dst_sel_o,
    output logic        alu_src_o,
    output logic [2:0]  alu_op_o,
    output logic        mem_we_o,
    output logic [1:0]  result_sel_o,
    output logic        branch_o,
    output logic        illegal_o
);
    opc_e            opc;
    logic [FN_W-1:0] fn;
    ctrl_t           ctrl;
    imk_e            imk;

    isa16_fields i_fields (
        .word_i (instr_i),
        .opc_o  (opc),
        .fn_o   (fn),
        .rs_o   (rs_o),
        .rt_o   (rt_o),
        .rd_o   (rd_o)
    );

    isa16_ctrl i_ctrl (
        .opc_i  (opc),
        .fn_i   (fn),
        .ctrl_o (ctrl),
        .imk_o  (imk)
    );

    isa16_imm i_imm (
        .word_i (instr_i),
        .imk_i  (imk),
        .imm_o  (imm_o)
    );

    assign reg_we_o     = ctrl.reg_we;
    assign dst_sel_o    = ctrl.dst_sel;
    assign alu_src_o    = ctrl.alu_src;
    assign alu_op_o     = ctrl.alu_op;
    assign mem_we_o     = ctrl.mem_we;
    assign result_sel_o = ctrl.res_sel;
    assign branch_o     = ctrl.branch;
    assign illegal_o    = ctrl.illegal;
endmodule

// File: rtl/isa16_decoder_chk.sv
module isa16_decoder_chk (
    input logic [15:0] instr_i,
    input logic [2:0]  rs_o,
    input logic [2:0]  rt_o,
    input logic [2:0]  rd_o,
    input logic [15:0] imm_o,
    input logic        reg_we_o,
    input logic        dst_sel_o,
    input logic        alu_src_o,
    input logic [2:0]  alu_op_o,
    input logic        mem_we_o,
    input logic [1:0]  result_sel_o,
    input logic        branch_o,
    input logic        illegal_o
);
    always_comb begin
        // R9: an illegal word leaves every control and the immediate at zero
        p_illegal_quiet_r9: assert (!illegal_o ||
            (!reg_we_o && !mem_we_o && !branch_o && !alu_src_o && !dst_sel_o &&
             alu_op_o == 3'b000 && result_sel_o == 2'b00 && imm_o == 16'h0000))
            else $error("illegal word drives a control line");
        // R8: the branch flag never comes with a write
        p_branch_no_write_r8: assert (!branch_o || (!reg_we_o && !mem_we_o && instr_i[2:0] == 3'b011))
            else $error("branch with write or wrong opcode");
        // R7: a store never writes the register file
        p_store_no_regwr_r7: assert (!mem_we_o || (!reg_we_o && alu_src_o && alu_op_o == 3'b010))
            else $error("store control mismatch");
        // R11: write-address select tracks the register write
        p_dst_tracks_we_r11: assert (dst_sel_o == reg_we_o)
            else $error("dst select does not follow write enable");
        // R6: load-upper result carries six zero low bits
        p_upper_low_zero_r6: assert (result_sel_o != 2'b10 || imm_o[5:0] == 6'b0)
            else $error("upper immediate low bits not zero");
        // R4: ALU immediates are sign extended from bit 6
        p_imm_sext_r4: assert (!alu_src_o || imm_o[15:7] == {9{imm_o[6]}})
            else $error("immediate not sign extended");
        // R3: register fields never move
        p_fields_fixed_r3: assert (rt_o == instr_i[11:9] && rs_o == instr_i[8:6] && rd_o == instr_i[5:3])
            else $error("register field misplaced");
        // R1: at most one of the kinds of effect is signalled
        p_kind_onehot_r1: assert ($onehot0({reg_we_o, mem_we_o, branch_o, illegal_o}))
            else $error("more than one instruction kind");
    end
endmodule

bind isa16_decoder isa16_decoder_chk i_chk (.*);

// File: tb/test_isa16_decoder.sv
module test_isa16_decoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [15:0] instr_i;
    logic [2:0]  rs_o, rt_o, rd_o, alu_op_o;
    logic [15:0] imm_o;
    logic        reg_we_o, dst_sel_o, alu_src_o, mem_we_o, branch_o, illegal_o;
    logic [1:0]  result_sel_o;

    isa16_decoder i_isa16_decoder (
        .instr_i      (instr_i),
        .rs_o         (rs_o),
        .rt_o         (rt_o),
        .rd_o         (rd_o),
        .imm_o        (imm_o),
        .reg_we_o     (reg_we_o),
        .dst_sel_o    (dst_sel_o),
        .alu_src_o    (alu_src_o),
        .alu_op_o     (alu_op_o),
        .mem_we_o     (mem_we_o),
        .result_sel_o (result_sel_o),
        .branch_o     (branch_o),
        .illegal_o    (illegal_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // expected control vector: {reg_we, dst_sel, alu_src, alu_op[2:0], mem_we, res[1:0], branch, illegal}
    function automatic logic [10:0] exp_ctrl(input logic [15:0] w);
        logic [2:0] op;
        op = w[2:0];
        case (w[2:0])
            3'b001: begin
                case (w[15:12])
                    4'b0001: op = 3'b001;
                    4'b0010: op = 3'b000;
                    4'b0011: op = 3'b010;
                    4'b0111: op = 3'b110;
                    4'b1111: op = 3'b111;
                    default: return 11'b000_000_0_00_0_1;
                endcase
                return {1'b1, 1'b1, 1'b0, op, 1'b0, 2'b00, 1'b0, 1'b0};
            end
            3'b010: return {3'b111, 3'b010, 1'b0, 2'b00, 2'b00};
            3'b100: return {3'b111, 3'b010, 1'b0, 2'b01, 2'b00};
            3'b101: return {3'b001, 3'b010, 1'b1, 2'b00, 2'b00};
            3'b011: return {3'b000, 3'b000, 1'b0, 2'b00, 2'b10};
            3'b110: return {3'b110, 3'b000, 1'b0, 2'b10, 2'b00};
            default: return 11'b000_000_0_00_0_1;
        endcase
    endfunction

    function automatic logic [15:0] exp_imm(input logic [15:0] w);
        logic [6:0] v;
        case (w[2:0])
            3'b010, 3'b100: begin
                v = {w[15:12], w[11:9]};
                return {{9{v[6]}}, v};
            end
            3'b011, 3'b101: begin
                v = {w[15:12], w[5:3]};
                return {{9{v[6]}}, v};
            end
            3'b110: return {w[15:6], 6'b000000};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string req_of(input logic [15:0] w);
        case (w[2:0])
            3'b001: return (exp_ctrl(w) & 11'h001) != 0 ? "R2" : "R10";
            3'b010, 3'b100: return "R4";
            3'b011, 3'b101: return "R5";
            3'b110: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s instr=%h actual=%h expected=%h", req, instr_i, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [15:0] w);
        logic [10:0] ec;
        @(posedge clk);
        #1 instr_i = w;
        @(negedge clk);
        ec = exp_ctrl(w);
        // R3 register fields
        check("R3", {23'b0, rt_o, rs_o, rd_o}, {23'b0, w[11:9], w[8:6], w[5:3]});
        check(req_of(w), {16'b0, imm_o}, {16'b0, exp_imm(w)});
        check(w[2:0] == 3'b011 ? "R8" : (w[2:0] == 3'b100 || w[2:0] == 3'b101 || w[2:0] == 3'b010) ? "R7" : "R1",
              {21'b0, reg_we_o, dst_sel_o, alu_src_o, alu_op_o, mem_we_o, result_sel_o, branch_o, illegal_o},
              {21'b0, ec});
        // R11 destination select follows write enable
        check("R11", {31'b0, dst_sel_o}, {31'b0, ec[10]});
    endtask

    initial begin
        int unsigned s;
        instr_i = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: word 0 is an illegal opcode, nothing may write (R9)
        check("R9", {29'b0, reg_we_o, mem_we_o, illegal_o}, {29'b0, 3'b001});
        rst = 1'b0;

        // R2 every operation nibble under the register opcode
        for (int f = 0; f < 16; f++) apply_and_check({f[3:0], 3'b101, 3'b011, 3'b110, 3'b001});
        // R1 reserved opcodes
        apply_and_check(16'hFFFF);
        apply_and_check(16'h1238);
        // R4 extremes of the middle-field immediate
        apply_and_check({4'b1000, 3'b000, 3'b010, 3'b011, 3'b010}); // -64 addi
        apply_and_check({4'b1111, 3'b111, 3'b001, 3'b100, 3'b100}); // -1 load
        apply_and_check({4'b0111, 3'b111, 3'b001, 3'b100, 3'b010}); // +63
        // R5 extremes of the split offset
        apply_and_check({4'b1000, 3'b101, 3'b011, 3'b000, 3'b011}); // -64 beq
        apply_and_check({4'b1111, 3'b000, 3'b011, 3'b111, 3'b101}); // -1 store
        apply_and_check({4'b0111, 3'b111, 3'b000, 3'b111, 3'b011}); // +63
        // R6 load-upper all ones and single bits
        apply_and_check({10'h3FF, 3'b111, 3'b110});
        apply_and_check({10'h001, 3'b010, 3'b110});
        apply_and_check({10'h200, 3'b000, 3'b110});

        s = $urandom(32'h5EED_0D1E);
        for (int i = 0; i < 3000; i++) apply_and_check(16'($urandom()));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule